// File: doc/BRIEF.md
# NOR Flash Multi-Sector Erase Sequencer

This block erases a run of consecutive, equally sized sectors of an 8-bit NOR flash with one command. When a request is accepted, it first checks that the request is legal. It then writes the six-step unlock-and-erase-setup sequence and issues one sector-erase command per sector. The commands go out back to back, so the flash takes them all as a single batch. Between queued commands the block reads back the sector just named and checks the flag that reports a closed acceptance window.

After the last command the block polls the status byte at the region start until the erase finishes or fails. On any failure after bus traffic has begun, it writes the reset command before it reports. A host starts it with a one-cycle `start`, waits for the one-cycle `done` pulse, and then reads `error`, `err_kind` and `fail_status`. These three outputs hold their values until the next accepted request.

The sequencer has seven states:
- `ST_IDLE`. A legal `start` goes to `ST_SETUP`. An illegal one goes to `ST_FINISH`.
- `ST_SETUP` issues the six setup writes. After the sixth it goes to `ST_SECT_CMD`.
- `ST_SECT_CMD` writes the erase command to one sector. Then it goes to `ST_SECT_CHK`, to the next sector, to `ST_POLL`, or to `ST_RECOVER` if the command was late.
- `ST_SECT_CHK` reads the sector just commanded. It then goes to the next `ST_SECT_CMD`, to `ST_POLL`, or to `ST_RECOVER` if the window flag is set.
- `ST_POLL` repeats status reads. It goes to `ST_FINISH` on success or to `ST_RECOVER` on failure.
- `ST_RECOVER` writes the reset command and goes to `ST_FINISH`.
- `ST_FINISH` pulses `done` and returns to `ST_IDLE`.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `bus_req` are low and `err_kind` is 0.
- R2: A request is rejected when any of these holds:
  - `start_addr` is not a multiple of the sector size.
  - `sector_count` is zero.
  - `start_addr + sector_count * sector_size` exceeds the device size.

  A rejected request makes no bus access and ends with `done`, `error` high and `err_kind` = 1. A region ending exactly at the device end is legal.
- R3: An accepted request first makes six writes, relative to the region start S, in this order:

  | Step | Address | Data |
  |---|---|---|
  | 1 | S+0x555 | 0xF0 |
  | 2 | S+0x555 | 0xAA |
  | 3 | S+0x2AA | 0x55 |
  | 4 | S+0x555 | 0x80 |
  | 5 | S+0x555 | 0xAA |
  | 6 | S+0x2AA | 0x55 |
- R4: Sector k (k = 0..N-1, in order) is erased by writing 0x30 to S + k*size. For every k >= 1, one read of S + k*size follows that write, and the next sector write comes after that read.
- R5: If a check read returns bit 3 set, no further sector command is sent. The block writes 0xF0 to S+0x555 and ends with `error` and `err_kind` = 2.
- R6: If more than GAP_CYCLES cycles pass between the acknowledge of one sector command and the acknowledge of the next, the late command is followed at once by the 0xF0 reset write. The request then ends with `err_kind` = 2. A slower but in-limit acknowledge has no effect.
- R7: Status polling reads S at least three times. From the third read on, a read with bit 7 high ends the request with `error` low and no reset write. A read with bit 7 low that differs from the previous read continues polling.
- R8: A read with bit 7 low that equals the previous read is a failure. Then:
  - `fail_status` captures the read made two reads earlier.
  - `err_kind` is 3 if bit 5 of that byte is set and 4 if it is clear.
  - 0xF0 is written to S+0x555 before `done`.
- R9: `start` has no effect while `busy` is high.
- R10: A bus request keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stable until the cycle in which `bus_ack` is high. A request completes in that cycle.
- R11: `busy` is high from the cycle after an accepted or rejected `start` through the cycle in which `done` is high. `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled only when idle |
| start_addr | input | ADDR_W | Byte address of the first sector |
| sector_count | input | CNT_W | Number of sectors to erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last request ended in error |
| err_kind | output | 3 | 0 none, 1 rejected, 2 window closed, 3 device fault, 4 erase not taken |
| fail_status | output | 8 | Status byte captured on a polling failure |
| bus_req | output | 1 | Flash access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Flash byte address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 8 | Read data, valid with bus_ack |

## Verification
The hardest case to reach is a late sector command: the window closes between two queued commands, even though the sequencer never idles between them. The bench's flash model holds back the acknowledge of the second sector write by a chosen number of cycles. It does this once beyond GAP_CYCLES and once within it, and the bus trace then shows the reset write in the first run and the normal check read in the second. Both polling failures are driven from scripted status sequences, so the byte captured two reads before the equal pair differs from the equal pair itself.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    typedef enum logic [2:0] {
        EK_NONE     = 3'd0,
        EK_REJECT   = 3'd1,
        EK_WINDOW   = 3'd2,
        EK_DEVICE   = 3'd3,
        EK_NOTTAKEN = 3'd4
    } err_kind_e;

    typedef enum logic [1:0] {
        PV_PENDING = 2'd0,
        PV_DONE    = 2'd1,
        PV_FAIL    = 2'd2
    } poll_verdict_e;

    localparam logic [11:0] OFS_HI = 12'h555;
    localparam logic [11:0] OFS_LO = 12'h2AA;
    localparam logic [7:0]  CMD_SECTOR = 8'h30;
    localparam logic [7:0]  CMD_RESET  = 8'hF0;
    localparam int unsigned SETUP_STEPS = 6;

    // offset of each setup write relative to the region start
    function automatic logic [11:0] setup_offset(input logic [2:0] step);
        logic [11:0] ofs;
        case (step)
            3'd2, 3'd5: ofs = OFS_LO;
            default:    ofs = OFS_HI;
        endcase
        return ofs;
    endfunction

    // data of each setup write
    function automatic logic [7:0] setup_data(input logic [2:0] step);
        logic [7:0] d;
        case (step)
            3'd0:       d = CMD_RESET;
            3'd1, 3'd4: d = 8'hAA;
            3'd2, 3'd5: d = 8'h55;
            default:    d = 8'h80;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/erase_req_check.sv
module erase_req_check #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned SECT_W = 16,
    parameter int unsigned DEV_W  = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output logic              legal
);
    localparam int unsigned SUM_W = ADDR_W + CNT_W + 1;

    logic [SUM_W-1:0] span_end;
    logic             aligned;
    logic             nonzero;
    logic             fits;

    always_comb begin
        span_end = SUM_W'(addr) + (SUM_W'(count) << SECT_W);
        aligned  = (addr[SECT_W-1:0] == '0);
        nonzero  = (count != '0);
        fits     = (span_end <= (SUM_W'(1) << DEV_W));
        legal    = aligned && nonzero && fits;
    end

endmodule

// File: rtl/erase_gap_timer.sv
module erase_gap_timer #(
    parameter int unsigned GAP_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic arm,
    output logic late
);
    localparam int unsigned TW = $clog2(GAP_CYCLES + 1);
    localparam logic [TW-1:0] LIMIT = TW'(GAP_CYCLES);

    logic [TW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (clear) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (arm) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (armed && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign late = armed && (cnt == LIMIT);

    AST_ARM_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        arm && !clear |=> !late); // R6

endmodule

// File: rtl/erase_poll_judge.sv
module erase_poll_judge
    import nor_erase_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic [7:0]    rdata,
    output poll_verdict_e verdict,
    output logic [7:0]    captured
);
    logic [7:0] hist1;
    logic [7:0] hist2;
    logic [1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist1 <= '0;
            hist2 <= '0;
            seen  <= '0;
        end else if (clear) begin
            seen <= '0;
        end else if (sample) begin
            hist2 <= hist1;
            hist1 <= rdata;
            if (seen != 2'd2) seen <= seen + 2'd1;
        end
    end

    always_comb begin
        if (seen != 2'd2)         verdict = PV_PENDING;
        else if (rdata[7])        verdict = PV_DONE;
        else if (rdata != hist1)  verdict = PV_PENDING;
        else                      verdict = PV_FAIL;
        captured = hist2;
    end

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned SECT_W     = 16,
    parameter int unsigned DEV_W      = 21,
    parameter int unsigned GAP_CYCLES = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  sector_count,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [2:0]        err_kind,
    output logic [7:0]        fail_status,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata
);
    localparam logic [ADDR_W-1:0] SECT_BYTES = ADDR_W'(1) << SECT_W;
    localparam logic [2:0]        LAST_STEP  = 3'(SETUP_STEPS - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_SECT_CMD, ST_SECT_CHK,
        ST_POLL, ST_RECOVER, ST_FINISH
    } state_e;

    state_e            state, state_d;
    logic [2:0]        step, step_d;
    logic [CNT_W-1:0]  idx, idx_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [ADDR_W-1:0] sect_q, sect_d;
    err_kind_e         ek_q, ek_d;
    logic [7:0]        fail_q, fail_d;

    logic          legal;
    logic          late;
    poll_verdict_e verdict;
    logic [7:0]    captured;

    erase_req_check #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SECT_W(SECT_W), .DEV_W(DEV_W)
    ) u_check (
        .addr (start_addr),
        .count(sector_count),
        .legal(legal)
    );

    erase_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(state == ST_IDLE),
        .arm  (state == ST_SECT_CMD && bus_ack),
        .late (late)
    );

    erase_poll_judge u_judge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state != ST_POLL),
        .sample  (state == ST_POLL && bus_ack),
        .rdata   (bus_rdata),
        .verdict (verdict),
        .captured(captured)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            step   <= '0;
            idx    <= '0;
            cnt_q  <= '0;
            base_q <= '0;
            sect_q <= '0;
            ek_q   <= EK_NONE;
            fail_q <= '0;
        end else begin
            state  <= state_d;
            step   <= step_d;
            idx    <= idx_d;
            cnt_q  <= cnt_d;
            base_q <= base_d;
            sect_q <= sect_d;
            ek_q   <= ek_d;
            fail_q <= fail_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state;
        step_d  = step;
        idx_d   = idx;
        cnt_d   = cnt_q;
        base_d  = base_q;
        sect_d  = sect_q;
        ek_d    = ek_q;
        fail_d  = fail_q;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    fail_d = '0;
                    if (legal) begin
                        state_d = ST_SETUP;
                        ek_d    = EK_NONE;
                        step_d  = '0;
                        idx_d   = '0;
                        cnt_d   = sector_count;
                        base_d  = start_addr;
                        sect_d  = start_addr;
                    end else begin
                        state_d = ST_FINISH;
                        ek_d    = EK_REJECT;
                    end
                end
            end
            ST_SETUP: begin
                if (bus_ack) begin
                    if (step == LAST_STEP) state_d = ST_SECT_CMD;
                    else                   step_d  = step + 3'd1;
                end
            end
            ST_SECT_CMD: begin
                if (bus_ack) begin
                    if (idx != '0 && late) begin
                        state_d = ST_RECOVER;
                        ek_d    = EK_WINDOW;
                    end else if (idx != '0) begin
                        state_d = ST_SECT_CHK;
                    end else if (cnt_q == CNT_W'(1)) begin
                        state_d = ST_POLL;
                    end else begin
                        idx_d  = idx + 1'b1;
                        sect_d = sect_q + SECT_BYTES;
                    end
                end
            end
            ST_SECT_CHK: begin
                if (bus_ack) begin
                    if (bus_rdata[3]) begin
                        state_d = ST_RECOVER;
                        ek_d    = EK_WINDOW;
                    end else if (idx == cnt_q - 1'b1) begin
                        state_d = ST_POLL;
                    end else begin
                        state_d = ST_SECT_CMD;
                        idx_d   = idx + 1'b1;
                        sect_d  = sect_q + SECT_BYTES;
                    end
                end
            end
            ST_POLL: begin
                if (bus_ack) begin
                    if (verdict == PV_DONE) begin
                        state_d = ST_FINISH;
                    end else if (verdict == PV_FAIL) begin
                        state_d = ST_RECOVER;
                        fail_d  = captured;
                        ek_d    = captured[5] ? EK_DEVICE : EK_NOTTAKEN;
                    end
                end
            end
            ST_RECOVER: begin
                if (bus_ack) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = base_q;
        bus_wdata = '0;
        unique case (state)
            ST_SETUP: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = base_q + ADDR_W'(setup_offset(step));
                bus_wdata = setup_data(step);
            end
            ST_SECT_CMD: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sect_q;
                bus_wdata = CMD_SECTOR;
            end
            ST_SECT_CHK: begin
                bus_req  = 1'b1;
                bus_addr = sect_q;
            end
            ST_POLL: begin
                bus_req  = 1'b1;
                bus_addr = base_q;
            end
            ST_RECOVER: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = base_q + ADDR_W'(OFS_HI);
                bus_wdata = CMD_RESET;
            end
            default: ;
        endcase
        busy        = (state != ST_IDLE);
        done        = (state == ST_FINISH);
        error       = (ek_q != EK_NONE);
        err_kind    = ek_q;
        fail_status = fail_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R10
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req && !done); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R11
    AST_POLL_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_POLL |-> bus_req && !bus_we && bus_addr == base_q); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(base_q) && $stable(cnt_q)); // R9

endmodule

// File: tb/tb_nor_erase_seq.sv
module tb_nor_erase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int CW = 8;
    localparam int SW = 12;
    localparam int DW = 18;
    localparam int GAP = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] sector_count = '0;
    logic          busy, done, error;
    logic [2:0]    err_kind;
    logic [7:0]    fail_status;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_ack = 1'b0;
    logic [7:0]    bus_rdata = '0;

    nor_erase_seq #(.ADDR_W(AW), .CNT_W(CW), .SECT_W(SW), .DEV_W(DW), .GAP_CYCLES(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .sector_count(sector_count), .busy(busy), .done(done), .error(error),
        .err_kind(err_kind), .fail_status(fail_status), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_tag = "R3";

    logic [AW+8:0] exp_q[$];
    logic [7:0]    poll_q[$];
    logic [7:0]    poll_last = 8'h00;
    logic [AW-1:0] poll_addr = '0;
    logic [AW-1:0] bad_addr = '1;
    int            txn_idx = 0;
    int            stall_idx = -1;
    int            stall_left = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit we, input logic [AW-1:0] a, input logic [7:0] d);
        exp_q.push_back({we, a, d});
    endtask

    task automatic push_setup(input logic [AW-1:0] s);
        push(1, s + 20'h555, 8'hF0);
        push(1, s + 20'h555, 8'hAA);
        push(1, s + 20'h2AA, 8'h55);
        push(1, s + 20'h555, 8'h80);
        push(1, s + 20'h555, 8'hAA);
        push(1, s + 20'h2AA, 8'h55);
    endtask

    function automatic logic [AW-1:0] sec(input logic [AW-1:0] s, input int k);
        return s + AW'(k << SW);
    endfunction

    // flash model and scoreboard monitor, acting at falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (txn_idx == stall_idx && stall_left > 0) begin
                    stall_left--;
                end else begin
                    if (exp_q.size() == 0) begin
                        check(0, cur_tag, "unexpected bus access addr", 32'(bus_addr), 32'h0);
                    end else begin
                        logic [AW+8:0] e;
                        e = exp_q.pop_front();
                        check(bus_we == e[AW+8], cur_tag, "access direction", 32'(bus_we), 32'(e[AW+8]));
                        check(bus_addr == e[AW+7:8], cur_tag, "access address", 32'(bus_addr), 32'(e[AW+7:8]));
                        if (e[AW+8])
                            check(bus_wdata == e[7:0], cur_tag, "write data", 32'(bus_wdata), 32'(e[7:0]));
                    end
                    if (!bus_we) begin
                        if (bus_addr == poll_addr) begin
                            if (poll_q.size() > 0) poll_last = poll_q.pop_front();
                            bus_rdata = poll_last;
                        end else begin
                            bus_rdata = (bus_addr == bad_addr) ? 8'h08 : 8'h00;
                        end
                    end
                    bus_ack = 1'b1;
                    txn_idx++;
                end
            end
        end
    end

    task automatic run_case(input string tag, input logic [AW-1:0] s, input logic [CW-1:0] n,
                            input logic [2:0] kind, input logic [7:0] fstat, input bit poke);
        int waited;
        cur_tag = tag;
        txn_idx = 0;
        poll_addr = s;
        poll_last = 8'h00;
        @(negedge clk);
        start = 1'b1;
        start_addr = s;
        sector_count = n;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", "busy after start", 32'(busy), 32'h1);
        waited = 0;
        while (!done && waited < 5000) begin
            if (poke && waited == 3) begin
                start = 1'b1;               // R9: request while busy
                start_addr = 20'h00000;
                sector_count = 8'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        check(done == 1'b1, tag, "done reached", 32'(done), 32'h1);
        check(error == (kind != 3'd0), tag, "error flag", 32'(error), 32'(kind != 3'd0));
        check(err_kind == kind, tag, "err_kind", 32'(err_kind), 32'(kind));
        if (kind >= 3'd3)
            check(fail_status == fstat, tag, "fail_status", 32'(fail_status), 32'(fstat));
        check(exp_q.size() == 0, tag, "missing bus accesses", 32'(exp_q.size()), 32'h0);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R11", "done single pulse", 32'({done, busy}), 32'h0);
        exp_q.delete();
        stall_idx = -1;
        bad_addr = '1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && error == 0 && bus_req == 0 && err_kind == 0,
              "R1", "reset outputs", 32'({busy, done, error, bus_req, err_kind}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_req == 0 && busy == 0, "R1", "idle after reset", 32'({bus_req, busy}), 32'h0);

        // R3 R4 R7 R9: three sectors, toggling status, then bit 7 high; start poked while busy
        push_setup(20'h02000);
        push(1, sec(20'h02000, 0), 8'h30);
        push(1, sec(20'h02000, 1), 8'h30);
        push(0, sec(20'h02000, 1), 8'h00);
        push(1, sec(20'h02000, 2), 8'h30);
        push(0, sec(20'h02000, 2), 8'h00);
        for (int i = 0; i < 5; i++) push(0, 20'h02000, 8'h00);
        poll_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h80};
        run_case("R4", 20'h02000, 8'd3, 3'd0, 8'h00, 1'b1);

        // R2 R7: region ending exactly at device end, minimum three status reads
        push_setup(20'h3E000);
        push(1, sec(20'h3E000, 0), 8'h30);
        push(1, sec(20'h3E000, 1), 8'h30);
        push(0, sec(20'h3E000, 1), 8'h00);
        for (int i = 0; i < 3; i++) push(0, 20'h3E000, 8'h00);
        poll_q = '{8'h80};
        run_case("R7", 20'h3E000, 8'd2, 3'd0, 8'h00, 1'b0);

        // R5: bit 3 on the check read of sector 1
        bad_addr = sec(20'h10000, 1);
        push_setup(20'h10000);
        push(1, sec(20'h10000, 0), 8'h30);
        push(1, sec(20'h10000, 1), 8'h30);
        push(0, sec(20'h10000, 1), 8'h00);
        push(1, 20'h10555, 8'hF0);
        run_case("R5", 20'h10000, 8'd3, 3'd2, 8'h00, 1'b0);

        // R6: second sector acknowledge held far beyond the limit
        stall_idx = 7;
        stall_left = 60;
        push_setup(20'h00000);
        push(1, sec(20'h00000, 0), 8'h30);
        push(1, sec(20'h00000, 1), 8'h30);
        push(1, 20'h00555, 8'hF0);
        run_case("R6", 20'h00000, 8'd2, 3'd2, 8'h00, 1'b0);

        // R6: held acknowledge still inside the limit has no effect
        stall_idx = 7;
        stall_left = 20;
        push_setup(20'h08000);
        push(1, sec(20'h08000, 0), 8'h30);
        push(1, sec(20'h08000, 1), 8'h30);
        push(0, sec(20'h08000, 1), 8'h00);
        for (int i = 0; i < 3; i++) push(0, 20'h08000, 8'h00);
        poll_q = '{8'h80};
        run_case("R6", 20'h08000, 8'd2, 3'd0, 8'h00, 1'b0);

        // R8: stuck status, captured byte has bit 5 set
        push_setup(20'h04000);
        push(1, sec(20'h04000, 0), 8'h30);
        for (int i = 0; i < 4; i++) push(0, 20'h04000, 8'h00);
        push(1, 20'h04555, 8'hF0);
        poll_q = '{8'h40, 8'h20, 8'h00, 8'h00};
        run_case("R8", 20'h04000, 8'd1, 3'd3, 8'h20, 1'b0);

        // R8: stuck status, captured byte has bit 5 clear
        push_setup(20'h05000);
        push(1, sec(20'h05000, 0), 8'h30);
        for (int i = 0; i < 4; i++) push(0, 20'h05000, 8'h00);
        push(1, 20'h05555, 8'hF0);
        poll_q = '{8'h00, 8'h40, 8'h44, 8'h44};
        run_case("R8", 20'h05000, 8'd1, 3'd4, 8'h40, 1'b0);

        // R2: rejections without bus traffic
        run_case("R2", 20'h01010, 8'd1, 3'd1, 8'h00, 1'b0);
        run_case("R2", 20'h01000, 8'd0, 3'd1, 8'h00, 1'b0);
        run_case("R2", 20'h3F000, 8'd2, 3'd1, 8'h00, 1'b0);

        // R10: error cleared by the next accepted request; handshake exercised throughout
        push_setup(20'h20000);
        push(1, sec(20'h20000, 0), 8'h30);
        for (int i = 0; i < 3; i++) push(0, 20'h20000, 8'h00);
        poll_q = '{8'hFF};
        run_case("R10", 20'h20000, 8'd1, 3'd0, 8'h00, 1'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule